// File: doc/BRIEF.md
# Four-Symbol Streaming Pattern Recognizer

This block watches a stream of symbols drawn from a four-letter alphabet {a, b, c, d} and decides, one symbol at a time, whether everything received since the last restart forms a complete word of the language `a? b? c+ (a*|b*) d (b|c)*`. A word may open with an optional a and then an optional b. A run of at least one c follows. After the c run comes either a run of a or a run of b, but not both kinds mixed. A single d closes that part, and any mix of b and c may follow it.

Each symbol arrives as a 2-bit code qualified by a valid strobe. A restart pulse returns the recognizer to its empty-word state. The `match` output is high whenever the prefix consumed so far is itself a complete word. The sticky `fail` output rises once the prefix can no longer be extended into any word, and it stays high until the next restart. The machine is a fixed deterministic automaton with a trap state, so a rejected stream costs no further work.

Top module: `pattern_recognizer`

## Requirements
- R1: Symbols are coded a=2'b00, b=2'b01, c=2'b10, d=2'b11. After each accepted symbol, `match` is 1 exactly when the whole prefix since the last restart is a word of `a? b? c+ (a*|b*) d (b|c)*`.
- R2: `match` is 0 for every prefix that is not yet complete, for example after "c" or "abcc". It is 1 after "cd" and after "abccd".
- R3: After the c run, a stream that mixes a and b before the d (for example "cab" or "cba") sets `fail`.
- R4: Once the d has been taken, each further b or c keeps `match` at 1. An a or a second d clears `match` and sets `fail`.
- R5: `fail` is 1 exactly when the prefix can no longer be completed into a word. Once set, it stays 1 until a restart, and `match` and `fail` are never 1 together.
- R6: A restart returns the machine to the empty-word state, so both outputs read 0 in the following cycle. When the restart and a valid symbol arrive in the same cycle, the symbol is discarded.
- R7: In a cycle with neither restart nor a valid symbol, both outputs hold their values.
- R8: While reset is asserted, and after it is released, `match` and `fail` are 0.
- R9: Both outputs are registered. A symbol taken on a clock edge affects them only after that edge, never combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Restart pulse, returns to the empty-word state |
| sym_valid | input | 1 | Qualifies `sym` for this cycle |
| sym | input | 2 | Symbol code (a=00, b=01, c=10, d=11) |
| match | output | 1 | The prefix consumed so far is a complete word |
| fail | output | 1 | Sticky flag: the prefix can no longer become a word |

## Verification
The restart and a valid symbol can land on the same clock edge. The restart must win, and the symbol must leave no trace. The bench provokes this in two ways. First, it pairs the restart with a d, which would kill the word if it were taken. Second, it pairs the restart with a c and then feeds a lone d, which would match only if the discarded c had counted. It then checks that `fail` and `match` follow the empty-word state alone. Beyond that collision, every stream of up to six symbols is swept, and each intermediate output is compared with a direct parse of the prefix in the bench.

// File: rtl/prp_pkg.sv
package prp_pkg;
  localparam int SYM_W   = 2;
  localparam int STATE_W = 3;

  typedef enum logic [SYM_W-1:0] {
    SYM_A = 2'd0,
    SYM_B = 2'd1,
    SYM_C = 2'd2,
    SYM_D = 2'd3
  } sym_e;

  typedef enum logic [STATE_W-1:0] {
    ST_EMPTY  = 3'd0,
    ST_LEAD_A = 3'd1,
    ST_LEAD_B = 3'd2,
    ST_CRUN   = 3'd3,
    ST_ARUN   = 3'd4,
    ST_BRUN   = 3'd5,
    ST_TAIL   = 3'd6,
    ST_TRAP   = 3'd7
  } state_e;
endpackage

// File: rtl/prp_rst_sync.sv
module prp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/prp_next.sv
module prp_next
  import prp_pkg::*;
(
  input  state_e               state_q,
  input  logic                 start,
  input  logic                 sym_valid,
  input  logic [SYM_W-1:0]     sym,
  output state_e               state_d
);
  sym_e s;
  state_e step;

  assign s = sym_e'(sym);

  always_comb begin
    step = ST_TRAP;
    unique case (state_q)
      ST_EMPTY: begin
        case (s)
          SYM_A:   step = ST_LEAD_A;
          SYM_B:   step = ST_LEAD_B;
          SYM_C:   step = ST_CRUN;
          default: step = ST_TRAP;
        endcase
      end
      ST_LEAD_A: begin
        case (s)
          SYM_B:   step = ST_LEAD_B;
          SYM_C:   step = ST_CRUN;
          default: step = ST_TRAP;
        endcase
      end
      ST_LEAD_B: step = (s == SYM_C) ? ST_CRUN : ST_TRAP;
      ST_CRUN: begin
        case (s)
          SYM_A:   step = ST_ARUN;
          SYM_B:   step = ST_BRUN;
          SYM_C:   step = ST_CRUN;
          default: step = ST_TAIL;
        endcase
      end
      ST_ARUN: begin
        case (s)
          SYM_A:   step = ST_ARUN;
          SYM_D:   step = ST_TAIL;
          default: step = ST_TRAP;
        endcase
      end
      ST_BRUN: begin
        case (s)
          SYM_B:   step = ST_BRUN;
          SYM_D:   step = ST_TAIL;
          default: step = ST_TRAP;
        endcase
      end
      ST_TAIL: step = (s == SYM_B || s == SYM_C) ? ST_TAIL : ST_TRAP;
      default: step = ST_TRAP;
    endcase
  end

  always_comb begin
    if (start)          state_d = ST_EMPTY;
    else if (sym_valid) state_d = step;
    else                state_d = state_q;
  end
endmodule

// File: rtl/prp_fail_flag.sv
module prp_fail_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic enter_trap,
  output logic fail
);
  logic fail_q, fail_d, fail_en;

  assign fail_en = start | enter_trap;

  always_comb begin
    if (start) fail_d = 1'b0;
    else       fail_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fail_q <= 1'b0;
    else if (fail_en) fail_q <= fail_d;
  end

  assign fail = fail_q;

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q && !start |=> fail_q); // R5
endmodule

// File: rtl/pattern_recognizer.sv
module pattern_recognizer
  import prp_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sym_valid,
  input  logic [SYM_W-1:0] sym,
  output logic             match,
  output logic             fail
);
  logic   rst_n_s;
  state_e state_q, state_d;
  logic   state_en;
  logic   enter_trap;

  prp_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  prp_next u_next (
    .state_q   (state_q),
    .start     (start),
    .sym_valid (sym_valid),
    .sym       (sym),
    .state_d   (state_d)
  );

  assign state_en   = start | sym_valid;
  assign enter_trap = (state_d == ST_TRAP);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)      state_q <= ST_EMPTY;
    else if (state_en) state_q <= state_d;
  end

  prp_fail_flag u_fail (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start      (start),
    .enter_trap (enter_trap),
    .fail       (fail)
  );

  assign match = (state_q == ST_TAIL);

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_s)
    start |=> (!match && !fail)); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!start && !sym_valid) |=> ($stable(match) && $stable(fail))); // R7
  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(match && fail)); // R5
  AST_NO_MIX: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_ARUN && sym_valid && !start && sym == SYM_B) |=> fail); // R3
  AST_TAIL_KEEP: assert property (@(posedge clk) disable iff (!rst_n_s)
    (match && sym_valid && !start && (sym == SYM_B || sym == SYM_C)) |=> match); // R4
  AST_TAIL_KILL: assert property (@(posedge clk) disable iff (!rst_n_s)
    (match && sym_valid && !start && (sym == SYM_A || sym == SYM_D)) |=> (fail && !match)); // R4
endmodule

// File: tb/pattern_recognizer_tb.sv
module pattern_recognizer_tb;
  localparam logic [1:0] A = 2'b00, B = 2'b01, C = 2'b10, D = 2'b11;

  logic clk = 1'b0;
  logic rst_n, start, sym_valid;
  logic [1:0] sym;
  logic match, fail;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pattern_recognizer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sym_valid(sym_valid),
    .sym(sym), .match(match), .fail(fail)
  );

  function automatic bit ref_match(input logic [1:0] s[8], input int n);
    int i = 0;
    int cn = 0;
    if (i < n && s[i] == A) i++;
    if (i < n && s[i] == B) i++;
    while (i < n && s[i] == C) begin i++; cn++; end
    if (cn == 0) return 0;
    if (i < n && s[i] == A) begin
      while (i < n && s[i] == A) i++;
    end else if (i < n && s[i] == B) begin
      while (i < n && s[i] == B) i++;
    end
    if (!(i < n && s[i] == D)) return 0;
    i++;
    while (i < n && (s[i] == B || s[i] == C)) i++;
    return i == n;
  endfunction

  function automatic bit ref_viable(input logic [1:0] s[8], input int n);
    logic [1:0] t1[8];
    logic [1:0] t2[8];
    t1 = s; t2 = s;
    t1[n] = D;
    t2[n] = C; t2[n+1] = D;
    return ref_match(s, n) || ref_match(t1, n + 1) || ref_match(t2, n + 2);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic st, input logic v, input logic [1:0] s);
    start = st; sym_valid = v; sym = s;
    @(negedge clk);
    start = 1'b0; sym_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [1:0] seq[8];
    rst_n = 1'b0; start = 1'b0; sym_valid = 1'b0; sym = 2'b00;
    repeat (3) @(negedge clk);
    chk("R8 match in reset", match, 1'b0);
    chk("R8 fail in reset", fail, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 match after reset", match, 1'b0);
    chk("R8 fail after reset", fail, 1'b0);

    // R1 R2 R5: exhaustive sweep over every stream of up to six symbols
    for (int len = 0; len <= 6; len++) begin
      for (int code = 0; code < (1 << (2 * len)); code++) begin
        for (int k = 0; k < 8; k++) seq[k] = A;
        drive(1'b1, 1'b0, A);
        chk("R6 match after restart", match, 1'b0);
        chk("R6 fail after restart", fail, 1'b0);
        for (int k = 0; k < len; k++) begin
          seq[k] = 2'((code >> (2 * k)) & 3);
          drive(1'b0, 1'b1, seq[k]);
          chk("R1 match vs parse", match, ref_match(seq, k + 1));
          chk("R5 fail vs viability", fail, !ref_viable(seq, k + 1));
        end
      end
    end

    // R2 directed
    drive(1'b1, 1'b0, A); drive(1'b0, 1'b1, A); drive(1'b0, 1'b1, B);
    drive(1'b0, 1'b1, C); drive(1'b0, 1'b1, C);
    chk("R2 abcc incomplete", match, 1'b0);
    drive(1'b0, 1'b1, D);
    chk("R2 abccd complete", match, 1'b1);

    // R3 mixed runs
    drive(1'b1, 1'b0, A); drive(1'b0, 1'b1, C); drive(1'b0, 1'b1, A);
    drive(1'b0, 1'b1, B);
    chk("R3 cab fails", fail, 1'b1);
    drive(1'b1, 1'b0, A); drive(1'b0, 1'b1, C); drive(1'b0, 1'b1, B);
    drive(1'b0, 1'b1, A);
    chk("R3 cba fails", fail, 1'b1);

    // R4 tail behaviour, R9 registered outputs, R7 idle holds
    drive(1'b1, 1'b0, A); drive(1'b0, 1'b1, C);
    start = 1'b0; sym_valid = 1'b1; sym = D;
    #1 chk("R9 no combinational path", match, 1'b0);
    @(negedge clk); sym_valid = 1'b0;
    chk("R9 match after edge", match, 1'b1);
    drive(1'b0, 1'b1, B); chk("R4 tail b keeps match", match, 1'b1);
    drive(1'b0, 1'b1, C); chk("R4 tail c keeps match", match, 1'b1);
    repeat (3) drive(1'b0, 1'b0, D);
    chk("R7 idle holds match", match, 1'b1);
    drive(1'b0, 1'b1, D);
    chk("R4 second d clears match", match, 1'b0);
    chk("R4 second d sets fail", fail, 1'b1);
    repeat (3) drive(1'b0, 1'b1, C);
    chk("R5 fail sticky", fail, 1'b1);
    repeat (2) drive(1'b0, 1'b0, C);
    chk("R7 idle holds fail", fail, 1'b1);

    // R6 restart collides with a valid symbol
    drive(1'b1, 1'b1, D);
    chk("R6 restart+d fail", fail, 1'b0);
    chk("R6 restart+d match", match, 1'b0);
    drive(1'b0, 1'b1, C); drive(1'b0, 1'b1, D);
    chk("R6 cd after collision", match, 1'b1);
    drive(1'b1, 1'b1, C);
    drive(1'b0, 1'b1, D);
    chk("R6 discarded c match", match, 1'b0);
    chk("R6 discarded c fail", fail, 1'b1);

    finish_run();
  end
endmodule